// File: doc/BRIEF.md
# Vector Structure Store Interleaver

This block turns the contents of up to four 128-bit vector registers into the byte image that a structure store writes to memory. A structure holds N equally sized elements, one from each of the N source registers. The block lays the structures out one after another, so element j of every structure comes from register j. Element sizes of 1, 2, 4 and 8 bytes are supported. A single-lane mode writes just one element from each register: the chosen lane, forming one structure of N elements.

The block also does the post-index address arithmetic of the store. In register mode the base address is used and no write-back occurs. In immediate post-index mode the immediate must equal the number of bytes moved; the new base is the old one plus that immediate. In register post-index mode any offset value is added, which supports strided walks such as going down an image column. A request is captured on a clock edge. One cycle later the block presents the write data, a contiguous byte-enable, the transfer length, the write address and the write-back address. Two flags come with these results: one reports a request that cannot be issued, and one reports a base address that does not sit on an element boundary.

Top module: `vst_interleave`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, wr_valid_o, illegal_o, wb_en_o and misaligned_o are 0, and wr_be_o and wr_len_o are 0.
- R2: In multi-structure mode (lane_mode_i = 0), N = nstruct_i + 1 and element size E = 1 << esize_i bytes (esize_i 0, 1, 2, 3 = 1, 2, 4, 8 bytes). Output byte E*(s*N + j) + b equals byte E*s + b of register j, where s is the structure index, j < N and b < E. With N = 3 and E = 1, the output bytes are reg0 byte 0, reg1 byte 0, reg2 byte 0, reg0 byte 1, and so on.
- R3: In multi-structure mode, wr_len_o is 16*N bytes.
- R4: In single-lane mode (lane_mode_i = 1), the lane used is lane_i modulo 16/E. Output byte E*k + b equals byte E*lane + b of register k, for k < N. wr_len_o is N*E.
- R5: wr_be_o bits 0 to wr_len_o-1 are 1 and all higher bits are 0. Data bytes at or above wr_len_o are 0.
- R6: Results appear exactly one cycle after a cycle with req_valid_i high. A cycle without a request leaves wr_valid_o, illegal_o, wb_en_o and misaligned_o low in the next cycle.
- R7: wr_addr_o is the base address of the request. With amode_i = 0 (register), the store issues and wb_en_o stays 0.
- R8: With amode_i = 1 (immediate post-index) and imm_i equal to the transfer length, the store issues, wb_en_o is 1 and wb_addr_o is base + imm_i.
- R9: With amode_i = 1 and imm_i not equal to the transfer length, illegal_o is 1, and wr_valid_o and wb_en_o are 0.
- R10: With amode_i = 2 (register post-index), the store issues, wb_en_o is 1 and wb_addr_o is base + off_i, taken modulo 2^ADDR_W.
- R11: amode_i = 3 is reserved. It raises illegal_o, and wr_valid_o and wb_en_o stay 0.
- R12: misaligned_o is 1 when base modulo E is non-zero. A misaligned store that is otherwise legal is still issued with wr_valid_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Store request present this cycle |
| vreg_i | input | 4x128 | Source vector registers, register j in slice j |
| nstruct_i | input | 2 | Elements per structure minus one |
| esize_i | input | 2 | log2 of element size in bytes |
| lane_mode_i | input | 1 | 1 = single-lane store |
| lane_i | input | 4 | Lane index for single-lane mode |
| base_i | input | 64 | Base address |
| amode_i | input | 2 | 0 register, 1 post-index immediate, 2 post-index register, 3 reserved |
| imm_i | input | 8 | Immediate post-increment |
| off_i | input | 64 | Register post-increment |
| wr_valid_o | output | 1 | Store issued |
| illegal_o | output | 1 | Request rejected |
| misaligned_o | output | 1 | Base not aligned to element size |
| wr_data_o | output | 512 | Interleaved write data, byte 0 at bits 7:0 |
| wr_be_o | output | 64 | Byte enables |
| wr_len_o | output | 7 | Transfer length in bytes |
| wr_addr_o | output | 64 | Write address |
| wb_en_o | output | 1 | Base write-back enable |
| wb_addr_o | output | 64 | Updated base address |

## Verification
A wrong permutation entry or a bad selection between variants shows up as a single misplaced byte in wr_data_o one cycle after the request. It shows only for the structure count and element size that use that entry, so random stimulus sweeps all sixteen combinations in both modes. A wrong length calculation changes three outputs in the same cycle: wr_len_o, the width of the byte-enable, and whether an immediate is accepted. Address and flag errors appear in the same cycle as the data, and the idle check one cycle later catches any flag that stays set.

// File: rtl/vst_pkg.sv
package vst_pkg;
  localparam int unsigned MAX_REGS = 4;
  localparam int unsigned N_ESIZE  = 4;

  typedef enum logic [1:0] {
    AM_REG      = 2'd0,
    AM_POST_IMM = 2'd1,
    AM_POST_REG = 2'd2,
    AM_RSVD     = 2'd3
  } amode_e;
endpackage

// File: rtl/vst_perm.sv
// Fixed byte routing for multi-structure stores, one variant per structure count.
module vst_perm #(
  parameter  int unsigned REG_BYTES = 16,
  parameter  int unsigned EB        = 1,
  localparam int unsigned NREG      = vst_pkg::MAX_REGS,
  localparam int unsigned BUS_BYTES = NREG * REG_BYTES
) (
  input  logic [NREG-1:0][8*REG_BYTES-1:0] vreg_i,
  output logic [BUS_BYTES-1:0][7:0]        data_o [NREG]
);
  for (genvar n = 0; n < NREG; n++) begin : g_cnt
    localparam int unsigned NS = n + 1;
    for (genvar p = 0; p < BUS_BYTES; p++) begin : g_byte
      localparam int unsigned K   = p / EB;
      localparam int unsigned B   = p % EB;
      localparam int unsigned S   = K / NS;
      localparam int unsigned J   = K % NS;
      localparam int unsigned SRC = S * EB + B;
      if (p < NS * REG_BYTES) begin : g_on
        assign data_o[n][p] = vreg_i[J][8*SRC +: 8];
      end else begin : g_off
        assign data_o[n][p] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/vst_lane_pick.sv
// Single-lane gather: one element per register, packed from byte 0.
module vst_lane_pick #(
  parameter  int unsigned REG_BYTES = 16,
  parameter  int unsigned EB        = 1,
  localparam int unsigned NREG      = vst_pkg::MAX_REGS,
  localparam int unsigned BUS_BYTES = NREG * REG_BYTES,
  localparam int unsigned LANE_W    = $clog2(REG_BYTES),
  localparam int unsigned LPR       = REG_BYTES / EB
) (
  input  logic [NREG-1:0][8*REG_BYTES-1:0] vreg_i,
  input  logic [LANE_W-1:0]                lane_i,
  output logic [BUS_BYTES-1:0][7:0]        data_o [NREG]
);
  logic [LANE_W-1:0]        lane_eff;
  logic [NREG-1:0][8*EB-1:0] elem;

  assign lane_eff = lane_i & LANE_W'(LPR - 1);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign elem[r] = vreg_i[r][8*EB*int'(lane_eff) +: 8*EB];
  end

  for (genvar n = 0; n < NREG; n++) begin : g_cnt
    for (genvar p = 0; p < BUS_BYTES; p++) begin : g_byte
      if (p < (n + 1) * EB) begin : g_on
        assign data_o[n][p] = elem[p/EB][8*(p%EB) +: 8];
      end else begin : g_off
        assign data_o[n][p] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/vst_agen.sv
// Post-index address generation and legality of the addressing form.
module vst_agen
  import vst_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned LEN_W  = 7
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [1:0]        amode_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              illegal_o
);
  amode_e            am;
  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] len_ext;

  assign am      = amode_e'(amode_i);
  assign imm_ext = ADDR_W'(imm_i);
  assign len_ext = ADDR_W'(len_i);

  always_comb begin
    wb_en_o   = 1'b0;
    wb_addr_o = base_i;
    illegal_o = 1'b0;
    unique case (am)
      AM_REG: ;
      AM_POST_IMM: begin
        wb_addr_o = base_i + imm_ext;
        if (imm_ext != len_ext) illegal_o = 1'b1;
        else                    wb_en_o   = 1'b1;
      end
      AM_POST_REG: begin
        wb_addr_o = base_i + off_i;
        wb_en_o   = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vst_interleave.sv
module vst_interleave
  import vst_pkg::*;
#(
  parameter  int unsigned REG_BYTES = 16,
  parameter  int unsigned ADDR_W    = 64,
  parameter  int unsigned IMM_W     = 8,
  localparam int unsigned REG_W     = 8 * REG_BYTES,
  localparam int unsigned BUS_BYTES = MAX_REGS * REG_BYTES,
  localparam int unsigned LANE_W    = $clog2(REG_BYTES),
  localparam int unsigned LEN_W     = $clog2(BUS_BYTES + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  input  logic [MAX_REGS-1:0][REG_W-1:0]    vreg_i,
  input  logic [1:0]                        nstruct_i,
  input  logic [1:0]                        esize_i,
  input  logic                              lane_mode_i,
  input  logic [LANE_W-1:0]                 lane_i,
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic [1:0]                        amode_i,
  input  logic [IMM_W-1:0]                  imm_i,
  input  logic [ADDR_W-1:0]                 off_i,
  output logic                              wr_valid_o,
  output logic                              illegal_o,
  output logic                              misaligned_o,
  output logic [8*BUS_BYTES-1:0]            wr_data_o,
  output logic [BUS_BYTES-1:0]              wr_be_o,
  output logic [LEN_W-1:0]                  wr_len_o,
  output logic [ADDR_W-1:0]                 wr_addr_o,
  output logic                              wb_en_o,
  output logic [ADDR_W-1:0]                 wb_addr_o
);
  logic [BUS_BYTES-1:0][7:0] perm_data [N_ESIZE][MAX_REGS];
  logic [BUS_BYTES-1:0][7:0] lane_data [N_ESIZE][MAX_REGS];

  for (genvar e = 0; e < N_ESIZE; e++) begin : g_esz
    vst_perm #(
      .REG_BYTES(REG_BYTES),
      .EB       (1 << e)
    ) i_perm (
      .vreg_i(vreg_i),
      .data_o(perm_data[e])
    );

    vst_lane_pick #(
      .REG_BYTES(REG_BYTES),
      .EB       (1 << e)
    ) i_lane (
      .vreg_i(vreg_i),
      .lane_i(lane_i),
      .data_o(lane_data[e])
    );
  end

  logic [2:0]                n_regs;
  logic [LEN_W-1:0]          len_nxt;
  logic [BUS_BYTES-1:0][7:0] data_nxt;
  logic [BUS_BYTES-1:0]      be_nxt;
  logic [2:0]                emask;
  logic                      misal_nxt;
  logic                      wb_en_nxt;
  logic                      illegal_nxt;
  logic [ADDR_W-1:0]         wb_addr_nxt;

  assign n_regs  = 3'(nstruct_i) + 3'd1;
  assign len_nxt = lane_mode_i ? LEN_W'(32'(n_regs) << esize_i)
                               : LEN_W'(32'(n_regs) * REG_BYTES);
  assign data_nxt = lane_mode_i ? lane_data[esize_i][nstruct_i]
                                : perm_data[esize_i][nstruct_i];

  always_comb begin
    for (int i = 0; i < BUS_BYTES; i++) be_nxt[i] = (LEN_W'(i) < len_nxt);
  end

  assign emask     = 3'((4'd1 << esize_i) - 4'd1);
  assign misal_nxt = |(base_i[2:0] & emask);

  vst_agen #(
    .ADDR_W(ADDR_W),
    .IMM_W (IMM_W),
    .LEN_W (LEN_W)
  ) i_agen (
    .base_i   (base_i),
    .off_i    (off_i),
    .amode_i  (amode_i),
    .imm_i    (imm_i),
    .len_i    (len_nxt),
    .wb_en_o  (wb_en_nxt),
    .wb_addr_o(wb_addr_nxt),
    .illegal_o(illegal_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o   <= 1'b0;
      illegal_o    <= 1'b0;
      misaligned_o <= 1'b0;
      wb_en_o      <= 1'b0;
      wr_data_o    <= '0;
      wr_be_o      <= '0;
      wr_len_o     <= '0;
      wr_addr_o    <= '0;
      wb_addr_o    <= '0;
    end else if (req_valid_i) begin
      wr_valid_o   <= !illegal_nxt;
      illegal_o    <= illegal_nxt;
      misaligned_o <= misal_nxt;
      wb_en_o      <= wb_en_nxt;
      wr_data_o    <= data_nxt;
      wr_be_o      <= be_nxt;
      wr_len_o     <= len_nxt;
      wr_addr_o    <= base_i;
      wb_addr_o    <= wb_addr_nxt;
    end else begin
      wr_valid_o   <= 1'b0;
      illegal_o    <= 1'b0;
      misaligned_o <= 1'b0;
      wb_en_o      <= 1'b0;
    end
  end
endmodule

// File: rtl/vst_interleave_chk.sv
module vst_interleave_chk #(
  parameter int unsigned BUS_BYTES = 64,
  parameter int unsigned LEN_W     = 7,
  parameter int unsigned ADDR_W    = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [1:0]           amode_i,
  input logic                 wr_valid_o,
  input logic                 illegal_o,
  input logic                 misaligned_o,
  input logic                 wb_en_o,
  input logic [BUS_BYTES-1:0] wr_be_o,
  input logic [LEN_W-1:0]     wr_len_o,
  input logic [ADDR_W-1:0]    wr_addr_o,
  input logic [ADDR_W-1:0]    wb_addr_o
);
  // R9
  issue_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_o, illegal_o}));

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!wr_valid_o && !illegal_o && !wb_en_o && !misaligned_o));

  // R5
  be_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($countones(wr_be_o) == 32'(wr_len_o)));

  // R5
  be_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ((wr_be_o & (wr_be_o + 1'b1)) == '0));

  // R7
  wb_needs_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wr_valid_o);

  // R8
  imm_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && $past(amode_i) == 2'd1) |-> (wb_addr_o == wr_addr_o + ADDR_W'(wr_len_o)));

  // R12
  misal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> $past(req_valid_i));
endmodule

bind vst_interleave vst_interleave_chk #(
  .BUS_BYTES(BUS_BYTES),
  .LEN_W    (LEN_W),
  .ADDR_W   (ADDR_W)
) i_vst_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .amode_i     (amode_i),
  .wr_valid_o  (wr_valid_o),
  .illegal_o   (illegal_o),
  .misaligned_o(misaligned_o),
  .wb_en_o     (wb_en_o),
  .wr_be_o     (wr_be_o),
  .wr_len_o    (wr_len_o),
  .wr_addr_o   (wr_addr_o),
  .wb_addr_o   (wb_addr_o)
);

// File: tb/test_vst_interleave.sv
`timescale 1ns/1ps
module test_vst_interleave;
  localparam int RB = 16;
  localparam int BB = 64;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_valid_i = 1'b0;
  logic [3:0][127:0]  vreg_i = '0;
  logic [1:0]         nstruct_i = '0;
  logic [1:0]         esize_i = '0;
  logic               lane_mode_i = 1'b0;
  logic [3:0]         lane_i = '0;
  logic [63:0]        base_i = '0;
  logic [1:0]         amode_i = '0;
  logic [7:0]         imm_i = '0;
  logic [63:0]        off_i = '0;
  logic               wr_valid_o, illegal_o, misaligned_o, wb_en_o;
  logic [511:0]       wr_data_o;
  logic [63:0]        wr_be_o;
  logic [6:0]         wr_len_o;
  logic [63:0]        wr_addr_o, wb_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  vst_interleave i_vst_interleave (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .vreg_i(vreg_i),
    .nstruct_i(nstruct_i), .esize_i(esize_i), .lane_mode_i(lane_mode_i), .lane_i(lane_i),
    .base_i(base_i), .amode_i(amode_i), .imm_i(imm_i), .off_i(off_i),
    .wr_valid_o(wr_valid_o), .illegal_o(illegal_o), .misaligned_o(misaligned_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .wr_len_o(wr_len_o),
    .wr_addr_o(wr_addr_o), .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o)
  );

  task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] ref_data(input logic [3:0][127:0] v, input int n, input int eb,
                                            input bit lm, input int lane);
    logic [511:0] d = '0;
    int len = lm ? n * eb : n * RB;
    int l = lane % (RB / eb);
    for (int p = 0; p < len; p++) begin
      int k = p / eb;
      int b = p % eb;
      int j, src;
      if (lm) begin j = k; src = l * eb + b; end
      else    begin j = k % n; src = (k / n) * eb + b; end
      d[8*p +: 8] = v[j][8*src +: 8];
    end
    return d;
  endfunction

  function automatic logic [3:0][127:0] rnd_regs();
    logic [3:0][127:0] v;
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 4; w++) v[r][32*w +: 32] = $urandom;
    return v;
  endfunction

  task automatic do_req(input logic [3:0][127:0] v, input int n, input int es, input bit lm,
                        input int lane, input logic [63:0] base, input int am,
                        input logic [7:0] imm, input logic [63:0] off);
    int eb = 1 << es;
    int len = lm ? n * eb : n * RB;
    bit ill = (am == 3) || (am == 1 && int'(imm) != len);
    bit wbe = !ill && (am == 1 || am == 2);
    logic [63:0] be_exp = '0;
    logic [63:0] wba = (am == 1) ? base + 64'(imm) : base + off;
    for (int i = 0; i < len; i++) be_exp[i] = 1'b1;
    @(negedge clk_i);
    vreg_i = v; nstruct_i = 2'(n - 1); esize_i = 2'(es); lane_mode_i = lm; lane_i = 4'(lane);
    base_i = base; amode_i = 2'(am); imm_i = imm; off_i = off; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(wr_valid_o == !ill, ill ? (am == 3 ? "R11 valid" : "R9 valid") : "R6 valid",
          512'(wr_valid_o), 512'(!ill));
    check(illegal_o == ill, am == 3 ? "R11 illegal" : "R9 illegal", 512'(illegal_o), 512'(ill));
    check(wb_en_o == wbe, am == 0 ? "R7 wb_en" : (am == 2 ? "R10 wb_en" : "R8 wb_en"),
          512'(wb_en_o), 512'(wbe));
    check(misaligned_o == ((base % eb) != 0), "R12 misaligned", 512'(misaligned_o),
          512'((base % eb) != 0));
    if (!ill) begin
      logic [511:0] de = ref_data(v, n, eb, lm, lane);
      check(wr_data_o == de, lm ? "R4 data" : "R2 data", wr_data_o, de);
      check(int'(wr_len_o) == len, lm ? "R4 len" : "R3 len", 512'(wr_len_o), 512'(len));
      check(wr_be_o == be_exp, "R5 be", 512'(wr_be_o), 512'(be_exp));
      check(wr_addr_o == base, "R7 addr", 512'(wr_addr_o), 512'(base));
      if (wbe) check(wb_addr_o == wba, am == 2 ? "R10 wb_addr" : "R8 wb_addr",
                     512'(wb_addr_o), 512'(wba));
    end
    @(negedge clk_i);
    check(!wr_valid_o && !illegal_o && !wb_en_o && !misaligned_o, "R6 idle",
          512'({wr_valid_o, illegal_o, wb_en_o, misaligned_o}), 512'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (2) @(negedge clk_i);
    check({wr_valid_o, illegal_o, wb_en_o, misaligned_o} == 4'b0, "R1 flags in reset",
          512'({wr_valid_o, illegal_o, wb_en_o, misaligned_o}), 512'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({wr_valid_o, illegal_o, wb_en_o, misaligned_o} == 4'b0 && wr_be_o == '0 && wr_len_o == '0,
          "R1 after reset", 512'({wr_valid_o, illegal_o, wb_en_o, wr_be_o, wr_len_o}), 512'(0));

    // Directed corners
    do_req(rnd_regs(), 3, 0, 0, 0, 64'h1000, 1, 8'd48, 64'd0);        // R2 R8 three-way bytes
    do_req(rnd_regs(), 2, 3, 0, 0, 64'h2000, 1, 8'd32, 64'd0);        // R8 two 64-bit elements
    do_req(rnd_regs(), 3, 0, 0, 0, 64'h1000, 1, 8'd40, 64'd0);        // R9 mismatch
    do_req(rnd_regs(), 4, 1, 0, 0, 64'h1000, 3, 8'd64, 64'd0);        // R11 reserved
    do_req(rnd_regs(), 3, 0, 0, 0, 64'h3000, 2, 8'd0, 64'h140);       // R10 stride
    do_req(rnd_regs(), 1, 2, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 2, 8'd0, 64'h20); // R10 wrap
    do_req(rnd_regs(), 4, 3, 1, 15, 64'h4000, 1, 8'd32, 64'd0);       // R4 lane wraps to 1
    do_req(rnd_regs(), 3, 0, 1, 4, 64'h4001, 1, 8'd3, 64'd0);         // R4 byte lane, R12 no flag
    do_req(rnd_regs(), 2, 2, 0, 0, 64'h5002, 1, 8'd32, 64'd0);        // R12 misaligned still issues
    do_req(rnd_regs(), 1, 1, 0, 0, 64'h6000, 0, 8'd0, 64'd0);         // R7 register mode
    do_req(rnd_regs(), 4, 0, 0, 0, 64'h7000, 1, 8'd64, 64'd0);        // R3 full bus

    // Random mix
    for (int t = 0; t < 400; t++) begin
      int n = int'($urandom_range(4, 1));
      int es = int'($urandom_range(3, 0));
      bit lm = 1'($urandom_range(1, 0));
      int am = int'($urandom_range(3, 0));
      int len = lm ? n * (1 << es) : n * RB;
      logic [7:0] imm = ($urandom_range(3, 0) != 0) ? 8'(len) : 8'($urandom);
      logic [63:0] base = {$urandom, $urandom};
      logic [63:0] off = {$urandom, $urandom};
      if (am == 3 && $urandom_range(3, 0) != 0) am = int'($urandom_range(2, 0));
      do_req(rnd_regs(), n, es, lm, int'($urandom_range(15, 0)), base, am, imm, off);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule